// File: doc/BRIEF.md
# BCD Time-of-Day Counter

This block keeps the time of day as three two-digit BCD fields: seconds, minutes and hours. A one-cycle enable arrives once per second and advances the seconds field. When seconds roll over, a carry advances minutes. When minutes roll over, a carry advances hours. When hours roll over from 23 to 00, a day carry pulse is produced for a following calendar stage.

Two adjust inputs let a user set the time by hand. Each adjust input is a one-cycle pulse that comes from an already debounced key. The minute key is merged by OR with the carry coming from seconds, and the hour key is merged the same way with the carry coming from minutes. A manual step therefore uses exactly the same increment and rollover logic as normal counting, and a minute adjust at 59 rolls into the hours.

Every carry is registered. A rollover in one field moves the next field one clock later, and the day carry is high for the single cycle in which the hours first show 00.

Top module: `tod_bcd_counter`

## Requirements
- R1: While the active-low reset is asserted, all three fields read 8'h00 and day_carry is 0.
- R2: Every field holds legal BCD at all times. The low nibble (bits 3:0) is 0 to 9. The high nibble (bits 7:4) is 0 to 5 for seconds and minutes. The hours never exceed 8'h23.
- R3: The seconds field steps by one BCD count on each clock edge where sec_tick is 1. It keeps its value on every other edge, whatever the adjust keys are doing.
- R4: On a tick while seconds read 8'h59, seconds become 8'h00. The minutes move by one on the following clock edge, not on the same edge.
- R5: A min_key pulse advances the minutes by one count on that edge. When min_key and the carry from seconds are active in the same cycle, the minutes still advance by only one count.
- R6: When the minutes advance from 8'h59 they become 8'h00, and the hours advance by one on the following clock edge.
- R7: An hour_key pulse advances the hours by one count on that edge. A key pulse and a minute carry in the same cycle advance the hours only once.
- R8: When the hours advance from 8'h23 they become 8'h00. day_carry is 1 exactly in the cycle that follows that edge, and it is 0 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| min_key | input | 1 | One-cycle minute adjust pulse |
| hour_key | input | 1 | One-cycle hour adjust pulse |
| sec_bcd | output | 8 | Seconds, two BCD digits (tens in 7:4) |
| min_bcd | output | 8 | Minutes, two BCD digits (tens in 7:4) |
| hour_bcd | output | 8 | Hours, two BCD digits (tens in 7:4) |
| day_carry | output | 1 | One-cycle pulse after the hours wrap to 00 |

## Verification
The assertions assume that sec_tick, min_key and hour_key are known, synchronous levels that the counter samples once per rising edge. The assertions do not need these inputs to be sparse, because any mix of tick and key pulses must keep the fields legal and the day pulse one cycle long. The stimulus changes the inputs only on falling edges. It draws random tick and key patterns from a seeded generator, with keys frequent enough to pass through many hour wraps. Directed sequences cover simultaneous key-and-carry cycles and the full cascade from 23:59:59.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DIGIT_W    = 4;
  localparam int FIELD_W    = 2 * DIGIT_W;
  localparam int NUM_FIELDS = 3;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

  typedef struct packed {
    logic [DIGIT_W-1:0] hi;
    logic [DIGIT_W-1:0] lo;
  } bcd_pair_t;

  // Last value of each field before it rolls over: 0 sec, 1 min, 2 hour
  function automatic bcd_pair_t wrap_of(input int idx);
    bcd_pair_t w;
    if (idx == NUM_FIELDS - 1) begin
      w.hi = 4'd2;
      w.lo = 4'd3;
    end else begin
      w.hi = 4'd5;
      w.lo = 4'd9;
    end
    return w;
  endfunction
endpackage

// File: rtl/tod_adv_merge.sv
module tod_adv_merge (
  input  logic carry_i,
  input  logic key_i,
  output logic adv_o
);
  // Manual key and lower-field carry share one increment request
  assign adv_o = carry_i | key_i;
endmodule

// File: rtl/tod_bcd_field.sv
module tod_bcd_field
  import tod_pkg::*;
#(
  parameter bcd_pair_t WRAP = '{hi: 4'd5, lo: 4'd9}
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      advance_i,
  output bcd_pair_t value_o,
  output logic      carry_o
);
  bcd_pair_t val_q, val_d;
  logic      carry_q, carry_d;
  logic      at_wrap;

  assign at_wrap = (val_q == WRAP);

  always_comb begin
    val_d   = val_q;
    carry_d = 1'b0;
    if (advance_i) begin
      if (at_wrap) begin
        val_d   = '0;
        carry_d = 1'b1;
      end else if (val_q.lo == DIGIT_MAX) begin
        val_d.hi = val_q.hi + 4'd1;
        val_d.lo = '0;
      end else begin
        val_d.lo = val_q.lo + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      val_q   <= val_d;
      carry_q <= carry_d;
    end
  end

  assign value_o = val_q;
  assign carry_o = carry_q;
endmodule

// File: rtl/tod_bcd_counter.sv
module tod_bcd_counter
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       min_key,
  input  logic       hour_key,
  output logic [7:0] sec_bcd,
  output logic [7:0] min_bcd,
  output logic [7:0] hour_bcd,
  output logic       day_carry
);
  bcd_pair_t [NUM_FIELDS-1:0]  vals;
  logic      [NUM_FIELDS-1:0]  adv;
  logic      [NUM_FIELDS-1:0]  carry;
  logic      [NUM_FIELDS-2:0]  keys;

  assign keys = {hour_key, min_key};

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam bcd_pair_t WRAP_I = wrap_of(i);
    if (i == 0) begin : g_base
      assign adv[i] = sec_tick;
    end else begin : g_chain
      tod_adv_merge u_merge (
        .carry_i (carry[i-1]),
        .key_i   (keys[i-1]),
        .adv_o   (adv[i])
      );
    end
    tod_bcd_field #(.WRAP(WRAP_I)) u_field (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance_i (adv[i]),
      .value_o   (vals[i]),
      .carry_o   (carry[i])
    );
  end

  assign sec_bcd   = vals[0];
  assign min_bcd   = vals[1];
  assign hour_bcd  = vals[NUM_FIELDS-1];
  assign day_carry = carry[NUM_FIELDS-1];
endmodule

// File: rtl/tod_bcd_checker.sv
module tod_bcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic       min_key,
  input logic       hour_key,
  input logic [7:0] sec_bcd,
  input logic [7:0] min_bcd,
  input logic [7:0] hour_bcd,
  input logic       day_carry
);
  p_bcd_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_bcd[3:0] <= 4'd9) && (sec_bcd[7:4] <= 4'd5) &&
    (min_bcd[3:0] <= 4'd9) && (min_bcd[7:4] <= 4'd5) &&
    (hour_bcd[3:0] <= 4'd9) && (hour_bcd <= 8'h23));

  p_sec_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable(sec_bcd));

  p_sec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && sec_bcd == 8'h59) |=> (sec_bcd == 8'h00));

  p_day_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |=> !day_carry);

  p_day_at_midnight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |-> (hour_bcd == 8'h00));

  p_hour_wrap_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_bcd == 8'h00 && $past(hour_bcd) == 8'h23) |-> day_carry);
endmodule

bind tod_bcd_counter tod_bcd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sec_tick  (sec_tick),
  .min_key   (min_key),
  .hour_key  (hour_key),
  .sec_bcd   (sec_bcd),
  .min_bcd   (min_bcd),
  .hour_bcd  (hour_bcd),
  .day_carry (day_carry)
);

// File: tb/tod_bcd_counter_bench.sv
`timescale 1ns/1ps
module tod_bcd_counter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0, min_key = 1'b0, hour_key = 1'b0;
  logic [7:0] sec_bcd, min_bcd, hour_bcd;
  logic       day_carry;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int ms, mm, mh;
  bit mc_sec, mc_min, mday;

  always #4 clk = ~clk;

  tod_bcd_counter u_tod_bcd_counter (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .min_key(min_key),
    .hour_key(hour_key), .sec_bcd(sec_bcd), .min_bcd(min_bcd),
    .hour_bcd(hour_bcd), .day_carry(day_carry)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic bit legal(input logic [7:0] v, input logic [7:0] top);
    return (v[3:0] <= 4'd9) && (v <= top);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_clear();
    ms = 0; mm = 0; mh = 0; mc_sec = 0; mc_min = 0; mday = 0;
  endtask

  // Cycle model built from R3-R8 with registered carries
  task automatic model_edge(input bit t, input bit mk, input bit hk);
    bit sadv, madv, hadv, nsc, nmc, nday;
    sadv = t; madv = mc_sec | mk; hadv = mc_min | hk;
    nsc  = sadv && ms == 59;
    nmc  = madv && mm == 59;
    nday = hadv && mh == 23;
    if (sadv) ms = (ms + 1) % 60;
    if (madv) mm = (mm + 1) % 60;
    if (hadv) mh = (mh + 1) % 24;
    mc_sec = nsc; mc_min = nmc; mday = nday;
  endtask

  task automatic check_all();
    chk("R3 seconds", sec_bcd, to_bcd(ms));
    chk("R5 R6 minutes", min_bcd, to_bcd(mm));
    chk("R7 hours", hour_bcd, to_bcd(mh));
    chk("R8 day_carry", {7'd0, day_carry}, {7'd0, mday});
    chk("R2 legal BCD", {7'd0, legal(sec_bcd, 8'h59) && legal(min_bcd, 8'h59)
                          && legal(hour_bcd, 8'h23)}, 8'd1);
  endtask

  task automatic step(input bit t, input bit mk, input bit hk);
    sec_tick = t; min_key = mk; hour_key = hk;
    @(posedge clk);
    model_edge(t, mk, hk);
    @(negedge clk);
    sec_tick = 0; min_key = 0; hour_key = 0;
    check_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    model_clear();
    @(negedge clk);
    @(negedge clk);
    chk("R1 sec in reset", sec_bcd, 8'h00);
    chk("R1 min in reset", min_bcd, 8'h00);
    chk("R1 hour in reset", hour_bcd, 8'h00);
    chk("R1 day in reset", {7'd0, day_carry}, 8'h00);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R3: keys do not touch seconds; R5/R7 single key steps
    repeat (3) step(0, 0, 0);
    step(0, 1, 0);
    chk("R3 seconds untouched by min_key", sec_bcd, 8'h00);
    chk("R5 min_key step", min_bcd, 8'h01);
    step(0, 0, 1);
    chk("R7 hour_key step", hour_bcd, 8'h01);
    chk("R3 seconds untouched by hour_key", sec_bcd, 8'h00);

    // R4: seconds wrap, minute moves one cycle later
    do_reset();
    repeat (59) step(1, 0, 0);
    step(1, 0, 0);
    chk("R4 seconds wrap", sec_bcd, 8'h00);
    chk("R4 minutes not yet", min_bcd, 8'h00);
    step(0, 0, 0);
    chk("R4 minutes after carry", min_bcd, 8'h01);
    // R5: key coincides with seconds carry -> one count
    repeat (59) step(1, 0, 0);
    step(1, 0, 0);
    step(0, 1, 0);
    chk("R5 key plus carry counts once", min_bcd, 8'h02);

    // R6/R8: full cascade from 23:59:59
    do_reset();
    repeat (23) step(0, 0, 1);
    repeat (59) step(0, 1, 0);
    repeat (59) step(1, 0, 0);
    chk("R8 setup hours", hour_bcd, 8'h23);
    step(1, 0, 0);
    chk("R6 minutes hold one cycle", min_bcd, 8'h59);
    step(0, 0, 0);
    chk("R6 minutes wrap", min_bcd, 8'h00);
    chk("R6 hours not yet", hour_bcd, 8'h23);
    step(0, 0, 0);
    chk("R8 hours wrap", hour_bcd, 8'h00);
    chk("R8 day pulse", {7'd0, day_carry}, 8'h01);
    step(0, 0, 0);
    chk("R8 day pulse ends", {7'd0, day_carry}, 8'h00);

    // R7/R8: hour key at 23 wraps with day carry
    do_reset();
    repeat (24) step(0, 0, 1);
    chk("R7 hour key wrap", hour_bcd, 8'h00);
    chk("R8 day pulse from key", {7'd0, day_carry}, 8'h01);

    // Random mix
    for (int n = 0; n < 5000; n++) begin
      bit t, mk, hk;
      t  = ($urandom % 2) == 0;
      mk = ($urandom % 6) == 0;
      hk = ($urandom % 5) == 0;
      step(t, mk, hk);
    end

    // R1: reset mid-run
    do_reset();
    step(0, 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule